// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers a set of interrupt request lines and offers one request at a time to a processor core. Each line passes through a synchronizer. A rising edge on a line latches a one-bit pending flag. Requests are not queued: an edge that arrives while the flag is already set is lost. Software sets up each source through a small write-only register bus. Each source has an enable bit, a 3-bit level, and a sub-priority from 0 to 8 within that level. A single global enable gates every request to the core.

Among the sources that are both pending and enabled, the controller selects the strongest one. It ranks first by level, then by sub-priority, and then by the lower source index. The selected source interrupts the core only when its level is strictly above the core's 3-bit mask. Level 7 passes even when the mask is 7. When the core acknowledges, the controller returns an 8-bit vector and clears the pending flag of the source that was taken. If nothing qualifies at that moment, the acknowledge returns a fixed spurious vector and clears nothing. A diagnostic output rises when two enabled sources share the same level and sub-priority.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A rising edge on `irq_in[i]` sets the pending flag of source i at the third rising clock edge after the input changes. The flag stays set until it is cleared. A line held high does not set the flag again after it is cleared.
- R2: An edge on a source whose flag is already pending is dropped, so a single acknowledge removes it completely.
- R3: `int_req` stays low while the global enable (bit 0 written at address NUM_SRC) is 0 or the source's enable bit is 0. The pending flag is kept and is offered again once enabled.
- R4: Source configuration is written at address i with data bit 0 = enable, bits 3:1 = level and bits 7:4 = sub-priority. A sub-priority above 8 saturates to 8. The selected source has the highest level, then the highest sub-priority, then the lowest index. When `int_req` is high, `int_level` carries the selected source's level; otherwise `int_level` is 0.
- R5: `int_req` is high only when the selected level is strictly greater than `cpu_mask` (or is 7). A level-0 source never interrupts.
- R6: A level-7 source raises `int_req` with `int_level` = 7 even when `cpu_mask` is 7.
- R7: When `int_ack` is high on a clock edge while `int_req` is high, the next cycle shows `vec_valid` high for exactly one cycle and `vec_out` = VEC_BASE (default 64) + source index. The pending flag of that source is cleared at the same edge.
- R8: When `int_ack` is high while `int_req` is low, `vec_out` becomes SPUR_VEC (default 24) and no pending flag changes.
- R9: Writing a mask at address NUM_SRC+1 clears the pending flag of every source whose bit is 1. If a new edge sets a flag in the same cycle that clears it, the new edge wins.
- R10: `cfg_err` is high whenever two enabled sources have the same level and sub-priority.
- R11: While `rst_n` is low, all flags and configuration are zero, and `int_req`, `int_level`, `vec_valid`, `vec_out` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | NUM_SRC | Request lines; may be asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| cpu_mask | input | 3 | Current processor interrupt mask |
| int_ack | input | 1 | Core accepts the interrupt |
| int_req | output | 1 | Qualified interrupt request |
| int_level | output | 3 | Level of the offered request |
| vec_valid | output | 1 | One-cycle pulse after an acknowledge |
| vec_out | output | 8 | Vector returned for the last acknowledge |
| cfg_err | output | 1 | Two enabled sources share level and sub-priority |

## Verification
Several rules are checked by assertions on every cycle:
- the offered level always beats the mask or is 7, and is never 0;
- no request is offered while the global enable is off;
- at mask 7, only level 7 gets through;
- a vector pulse always follows an acknowledge;
- a vector lands either in the source range or on the spurious value, depending on whether a request was offered.

Some behaviour can only be shown by the bench scenarios compared against its reference model:
- the three-edge arrival latency;
- requests dropped while a flag is pending;
- sub-priority saturation and tie-breaking by index;
- a flag that survives masking and disabling;
- a new edge winning over a same-cycle software clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int LVL_W = 3;
  localparam int SUB_W = 4;
  localparam int KEY_W = LVL_W + SUB_W;
  localparam logic [SUB_W-1:0] SUB_MAX = SUB_W'(8);

  typedef struct packed {
    logic             en;
    logic [LVL_W-1:0] lvl;
    logic [SUB_W-1:0] sub;
  } src_cfg_t;

  // Ranking key: level in the upper bits, sub-priority below it.
  function automatic logic [KEY_W-1:0] rank_key(input src_cfg_t c);
    return {c.lvl, c.sub};
  endfunction

endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic [NUM_SRC-1:0] rise
);

  logic [NUM_SRC-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= irq_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;

endmodule

// File: rtl/irqc_select.sv
module irqc_select
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] cand,
  input  src_cfg_t           cfg [NUM_SRC],
  output logic               found,
  output logic [IDX_W-1:0]   idx,
  output logic [LVL_W-1:0]   lvl
);

  logic [KEY_W-1:0] best;

  // Ascending scan with a strict compare: equal keys keep the lower index.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!found || (rank_key(cfg[i]) > best))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = rank_key(cfg[i]);
      end
    end
    lvl = best[KEY_W-1 -: LVL_W];
  end

endmodule

// File: rtl/irqc_dup_check.sv
module irqc_dup_check
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  src_cfg_t cfg [NUM_SRC],
  output logic     dup
);

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      for (int j = i + 1; j < NUM_SRC; j++) begin
        if (cfg[i].en && cfg[j].en && (rank_key(cfg[i]) == rank_key(cfg[j])))
          dup = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = (NUM_SRC > 8) ? NUM_SRC : 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [2:0]         cpu_mask,
  input  logic               int_ack,
  output logic               int_req,
  output logic [2:0]         int_level,
  output logic               vec_valid,
  output logic [7:0]         vec_out,
  output logic               cfg_err
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(NUM_SRC + 1);

  src_cfg_t           cfg_q [NUM_SRC];
  src_cfg_t           wr_cfg;
  logic [NUM_SRC-1:0] cfg_ld;
  logic               gen_q, gen_d, gen_ld;
  logic [NUM_SRC-1:0] pend_q, pend_d, clr, rise, en_vec, cand;
  logic [7:0]         vec_q, vec_d;
  logic               vval_q;
  logic               found, take;
  logic [IDX_W-1:0]   sel_idx;
  logic [2:0]         sel_lvl;

  irqc_edge_sync #(.NUM_SRC(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_en
    assign en_vec[g] = cfg_q[g].en;
  end
  assign cand = pend_q & en_vec;

  irqc_select #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_sel (
    .cand(cand), .cfg(cfg_q), .found(found), .idx(sel_idx), .lvl(sel_lvl)
  );

  irqc_dup_check #(.NUM_SRC(NUM_SRC)) u_dup (.cfg(cfg_q), .dup(cfg_err));

  assign take      = gen_q & found & ((sel_lvl > cpu_mask) | (sel_lvl == 3'd7));
  assign int_req   = take;
  assign int_level = take ? sel_lvl : 3'd0;
  assign vec_valid = vval_q;
  assign vec_out   = vec_q;

  // Configuration write decode.
  always_comb begin
    wr_cfg.en  = reg_wdata[0];
    wr_cfg.lvl = reg_wdata[3:1];
    wr_cfg.sub = (reg_wdata[7:4] > SUB_MAX) ? SUB_MAX : reg_wdata[7:4];
    for (int i = 0; i < NUM_SRC; i++)
      cfg_ld[i] = reg_we && (reg_addr == ADDR_W'(i));
    gen_ld = reg_we && (reg_addr == A_GLOBAL);
    gen_d  = reg_wdata[0];
  end

  // Pending and vector next state.
  always_comb begin
    clr = '0;
    if (reg_we && (reg_addr == A_CLEAR))
      clr = reg_wdata[NUM_SRC-1:0];
    if (int_ack && take)
      clr[sel_idx] = 1'b1;
    pend_d = rise | (pend_q & ~clr);
    vec_d  = take ? (8'(VEC_BASE) + 8'(sel_idx)) : 8'(SPUR_VEC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) cfg_q[i] <= '0;
      gen_q  <= 1'b0;
      pend_q <= '0;
      vec_q  <= '0;
      vval_q <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++)
        if (cfg_ld[i]) cfg_q[i] <= wr_cfg;
      if (gen_ld)  gen_q <= gen_d;
      if (int_ack) vec_q <= vec_d;
      pend_q <= pend_d;
      vval_q <= int_ack;
    end
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC  = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cpu_mask,
  input logic       int_ack,
  input logic       int_req,
  input logic [2:0] int_level,
  input logic       vec_valid,
  input logic [7:0] vec_out,
  input logic       glob_en
);

  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((int_level > cpu_mask) || (int_level == 3'd7)));

  p_lvl_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (int_level != 3'd0));

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !int_req);

  p_nmi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && (cpu_mask == 3'd7)) |-> (int_level == 3'd7));

  p_vec_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(int_ack));

  p_ack_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req) |=>
      ((vec_out >= 8'(VEC_BASE)) && (vec_out < 8'(VEC_BASE + NUM_SRC))));

  p_spur_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_req) |=> (vec_out == 8'(SPUR_VEC)));

endmodule

bind irq_prio_ctrl irqc_checker #(
  .NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE), .SPUR_VEC(SPUR_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_mask(cpu_mask), .int_ack(int_ack),
  .int_req(int_req), .int_level(int_level), .vec_valid(vec_valid),
  .vec_out(vec_out), .glob_en(gen_q)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/100ps
module test_irq_prio_ctrl;

  localparam int N = 8;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int VB = 64;
  localparam int SV = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [2:0]    cpu_mask;
  logic          int_ack;
  logic          int_req;
  logic [2:0]    int_level;
  logic          vec_valid;
  logic [7:0]    vec_out;
  logic          cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N), .ADDR_W(AW), .VEC_BASE(VB), .SPUR_VEC(SV)) i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cpu_mask(cpu_mask), .int_ack(int_ack), .int_req(int_req),
    .int_level(int_level), .vec_valid(vec_valid), .vec_out(vec_out), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_s1 [N], m_s2 [N], m_s3 [N], m_pend [N], m_en [N], m_lvl [N], m_sub [N];
  int m_gen, m_vq, m_vv;

  function automatic int m_best();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] != 0 && m_en[i] != 0)
        if (b < 0 || m_lvl[i] * 16 + m_sub[i] > m_lvl[b] * 16 + m_sub[b]) b = i;
    return b;
  endfunction

  function automatic int m_req(input int mask);
    int b = m_best();
    if (m_gen == 0 || b < 0) return 0;
    return (m_lvl[b] > mask || m_lvl[b] == 7) ? 1 : 0;
  endfunction

  function automatic int m_dup();
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (m_en[i] != 0 && m_en[j] != 0 && m_lvl[i] == m_lvl[j] && m_sub[i] == m_sub[j]) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_pend[i] = 0;
        m_en[i] = 0; m_lvl[i] = 0; m_sub[i] = 0;
      end
      m_gen = 0; m_vq = 0; m_vv = 0;
    end else begin
      int b, r;
      int clr [N];
      b = m_best();
      r = m_req(int'(cpu_mask));
      for (int i = 0; i < N; i++) clr[i] = 0;
      if (reg_we && int'(reg_addr) == N + 1)
        for (int i = 0; i < N; i++) clr[i] = int'(reg_wdata[i]);
      if (int_ack && r != 0) clr[b] = 1;
      m_vv = int'(int_ack);
      if (int_ack) m_vq = (r != 0) ? VB + b : SV;
      for (int i = 0; i < N; i++) begin
        if (m_s2[i] != 0 && m_s3[i] == 0) m_pend[i] = 1;
        else if (clr[i] != 0) m_pend[i] = 0;
      end
      if (reg_we && int'(reg_addr) < N) begin
        m_en[reg_addr]  = int'(reg_wdata[0]);
        m_lvl[reg_addr] = int'(reg_wdata[3:1]);
        m_sub[reg_addr] = (int'(reg_wdata[7:4]) > 8) ? 8 : int'(reg_wdata[7:4]);
      end
      if (reg_we && int'(reg_addr) == N) m_gen = int'(reg_wdata[0]);
      for (int i = 0; i < N; i++) begin
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = int'(irq_in[i]);
      end
    end
  end

  // Per-cycle comparison, half a nanosecond after the falling edge.
  always @(negedge clk) begin
    #0.5;
    if (!done) begin
      int er, b;
      er = m_req(int'(cpu_mask));
      b  = m_best();
      check(int'(int_req) == er, "R5 int_req vs model", int'(int_req), er);
      check(int'(int_level) == ((er != 0) ? m_lvl[b] : 0), "R4 int_level vs model",
            int'(int_level), (er != 0) ? m_lvl[b] : 0);
      check(int'(vec_valid) == m_vv, "R7 vec_valid vs model", int'(vec_valid), m_vv);
      check(int'(vec_out) == m_vq, "R7 vec_out vs model", int'(vec_out), m_vq);
      check(int'(cfg_err) == m_dup(), "R10 cfg_err vs model", int'(cfg_err), m_dup());
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
    tick();
    reg_we = 1'b0;
  endtask

  task automatic cfg(input int s, input int en, input int lvl, input int sub);
    wr(s, (sub << 4) | (lvl << 1) | en);
  endtask

  task automatic ack();
    int_ack = 1'b1;
    tick();
    int_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    cpu_mask = 3'd0; int_ack = 1'b0;
    repeat (3) tick();
    check(int_req == 1'b0 && int_level == 3'd0, "R11 req/level in reset", int'(int_req), 0);
    check(vec_valid == 1'b0 && vec_out == 8'd0, "R11 vector in reset", int'(vec_out), 0);
    check(cfg_err == 1'b0, "R11 cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    tick();

    // R1 arrival latency
    cfg(2, 1, 3, 1); wr(N, 1);
    irq_in[2] = 1'b1;
    tick(); tick();
    check(int_req == 1'b0, "R1 not yet pending", int'(int_req), 0);
    tick();
    check(int_req == 1'b1, "R1 pending after three edges", int'(int_req), 1);
    check(int_level == 3'd3, "R4 level of source 2", int'(int_level), 3);

    // R5 mask compare
    cpu_mask = 3'd3; tick();
    check(int_req == 1'b0, "R5 equal level masked", int'(int_req), 0);
    cpu_mask = 3'd2; tick();
    check(int_req == 1'b1, "R5 level above mask", int'(int_req), 1);

    // R3 gating keeps the flag
    wr(N, 0);
    check(int_req == 1'b0, "R3 global disable", int'(int_req), 0);
    wr(N, 1);
    check(int_req == 1'b1, "R3 global re-enable", int'(int_req), 1);
    cfg(2, 0, 3, 1);
    check(int_req == 1'b0, "R3 source disable", int'(int_req), 0);
    cfg(2, 1, 3, 1);
    check(int_req == 1'b1, "R3 source re-enable", int'(int_req), 1);

    // R7 acknowledge
    ack();
    check(vec_valid == 1'b1, "R7 vec_valid pulse", int'(vec_valid), 1);
    check(vec_out == 8'd66, "R7 vector of source 2", int'(vec_out), 66);
    check(int_req == 1'b0, "R7 flag cleared", int'(int_req), 0);
    tick();
    check(vec_valid == 1'b0, "R7 pulse one cycle", int'(vec_valid), 0);
    repeat (3) tick();
    check(int_req == 1'b0, "R1 held level no retrigger", int'(int_req), 0);
    irq_in[2] = 1'b0;

    // R2 dropped repeat
    cpu_mask = 3'd0;
    cfg(5, 1, 4, 0);
    irq_in[5] = 1'b1; repeat (3) tick();
    irq_in[5] = 1'b0; repeat (3) tick();
    irq_in[5] = 1'b1; repeat (3) tick();
    irq_in[5] = 1'b0; repeat (2) tick();
    check(int_req == 1'b1 && int_level == 3'd4, "R2 pending level 4", int'(int_level), 4);
    ack();
    check(vec_out == 8'd69, "R2 vector of source 5", int'(vec_out), 69);
    tick();
    check(int_req == 1'b0, "R2 second edge dropped", int'(int_req), 0);

    // R4 ranking and saturation
    cfg(1, 1, 2, 5); cfg(3, 1, 2, 7); cfg(4, 1, 2, 15); cfg(6, 1, 5, 0);
    irq_in = 8'b0101_1010;
    repeat (4) tick();
    irq_in = '0;
    check(int_level == 3'd5, "R4 highest level first", int'(int_level), 5);
    ack();
    check(vec_out == 8'd70, "R4 source 6", int'(vec_out), 70);
    ack();
    check(vec_out == 8'd68, "R4 saturated sub-priority wins", int'(vec_out), 68);
    ack();
    check(vec_out == 8'd67, "R4 sub-priority 7", int'(vec_out), 67);
    ack();
    check(vec_out == 8'd65, "R4 sub-priority 5", int'(vec_out), 65);

    // R10 duplicate rank and index tie-break
    cfg(0, 1, 6, 2); cfg(7, 1, 6, 2);
    check(cfg_err == 1'b1, "R10 duplicate flagged", int'(cfg_err), 1);
    irq_in[0] = 1'b1; irq_in[7] = 1'b1;
    repeat (4) tick();
    irq_in = '0;
    ack();
    check(vec_out == 8'd64, "R4 tie goes to lower index", int'(vec_out), 64);
    ack();
    check(vec_out == 8'd71, "R4 then source 7", int'(vec_out), 71);
    cfg(7, 1, 6, 3);
    check(cfg_err == 1'b0, "R10 duplicate resolved", int'(cfg_err), 0);

    // R6 non-maskable level
    cpu_mask = 3'd7;
    cfg(7, 1, 7, 0);
    irq_in[7] = 1'b1; repeat (4) tick(); irq_in[7] = 1'b0;
    check(int_req == 1'b1 && int_level == 3'd7, "R6 level 7 at mask 7", int'(int_level), 7);
    ack();
    check(vec_out == 8'd71, "R6 vector of source 7", int'(vec_out), 71);

    // R8 spurious acknowledge
    irq_in[6] = 1'b1; repeat (4) tick(); irq_in[6] = 1'b0;
    check(int_req == 1'b0, "R8 level 5 masked at 7", int'(int_req), 0);
    ack();
    check(vec_out == 8'd24, "R8 spurious vector", int'(vec_out), 24);
    cpu_mask = 3'd0; tick();
    check(int_req == 1'b1 && int_level == 3'd5, "R8 flag untouched", int'(int_level), 5);

    // R9 software clear and same-cycle set
    wr(N + 1, 1 << 6);
    check(int_req == 1'b0, "R9 software clear", int'(int_req), 0);
    irq_in[1] = 1'b1; tick(); tick();
    wr(N + 1, 1 << 1);
    check(int_req == 1'b1 && int_level == 3'd2, "R9 new edge beats clear", int'(int_req), 1);
    irq_in[1] = 1'b0;
    ack();
    check(vec_out == 8'd65, "R9 vector of source 1", int'(vec_out), 65);
    repeat (2) tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule